// File: doc/BRIEF.md
# Flash Command Controller with Phrase Programming

The block sequences commands on a small flash array kept in registers. Software loads an indexed command-object register file through a narrow register port. An index register selects the 16-bit slot that a data write reaches. The slots hold a command code, a 24-bit global byte address and the four data words of one 8-byte phrase. A launch strobe then starts the command.

Three commands exist: phrase program, sector erase and phrase read. The controller applies the cell rules. An erased byte holds 0xFF. Programming may only clear bits, and it is allowed only on an aligned phrase that is fully erased.

The array is split into two blocks that work independently. A separate read port serves byte and 16-bit word reads. A read waits while a command runs on the block it targets, and it completes normally when it targets the other block. Each command holds the array for a fixed, parameterised number of cycles. A completion flag, two error flags and an interrupt report the outcome.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the command-complete flag is 1, both error flags are 0, the interrupt enable is 0 and every array byte reads 0xFF.
- R2: The register port selects by regSel. Value 0 is the 3-bit slot index and value 1 is the data of the indexed slot. Value 2 is status: bit 7 is command complete, bit 5 is the access error and bit 4 is the program error. Value 3 is control, with bit 0 as the interrupt enable. Slot 0 holds the command code in bits 15:8 and address bits 23:16 in bits 7:0. Slot 1 holds address bits 15:0. Slots 2 to 5 hold the phrase words, and the high byte of slot 2 is the lowest address. Writes to slot 6 or 7 are discarded, and those slots read as 0.
- R3: A launch accepted with code 0x01 (read phrase), 0x02 (program phrase) or 0x03 (erase sector) clears the complete flag at the next edge. The flag then stays low for exactly READ_CYCLES, PROG_CYCLES or ERASE_CYCLES cycles, and it is set again at the end of that window.
- R4: While a command runs, a write to the index or to a slot, or a further launch, changes nothing and sets the access error.
- R5: A program command stores the four slot words into the addressed phrase. A program address whose low three bits are not zero sets the access error, and no command starts.
- R6: A program aimed at a phrase that is not all ones sets the program error and starts no command, and the phrase keeps its contents.
- R7: An erase sets all 256 bytes of the sector that holds the address to 0xFF and leaves every other sector unchanged.
- R8: A code other than 0x01, 0x02 or 0x03, or an address at or above the array size, sets the access error, and no command starts.
- R9: Writing a 1 to status bit 5 clears the access error, and writing a 1 to bit 4 clears the program error. A new error raised in the same cycle wins over the clear.
- R10: With rdReq held, a byte read or an aligned word read gives rdValid one cycle after the read is accepted, and a word read at an odd address gives it two cycles after. A word read returns the byte at the address in bits 15:8 and the next byte in bits 7:0. A byte read returns the byte zero-extended.
- R11: A read whose bytes fall in a block with a running command is held until that command completes. It then gives rdValid one cycle after the complete flag rises. A read of the other block is not delayed.
- R12: A read-phrase command loads the phrase at the address, with the low three bits ignored, into slots 2 to 5 when it completes.
- R13: The irq output is 1 exactly when the complete flag and the interrupt enable are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regSel | input | 2 | Register select for both write and read |
| regWdata | input | 16 | Register write data |
| regRdata | output | 16 | Register read data for regSel |
| launch | input | 1 | One-cycle command launch strobe |
| rdReq | input | 1 | Read request, held until rdValid |
| rdAddr | input | ADDR_W | Read byte address |
| rdWord | input | 1 | 1 for a word read, 0 for a byte read |
| rdValid | output | 1 | One-cycle read completion pulse |
| rdData | output | 16 | Read data |
| cmdDone | output | 1 | Command complete flag |
| accErr | output | 1 | Access error flag |
| progErr | output | 1 | Program-on-non-erased error flag |
| irq | output | 1 | Completion interrupt |

## Verification
The bench keeps the default geometry of two blocks, each with two 256-byte sectors. This puts cross-block reads and sector-boundary reads within reach. It overrides the timing to PROG_CYCLES=6, ERASE_CYCLES=12 and READ_CYCLES=2. These short windows let the exact busy length be counted, and they leave enough room to place locked register writes, a second launch, a read of the other block and a stalled read of the same block inside one erase.

// File: rtl/flashctl_pkg.sv
package flashctl_pkg;

  localparam logic [7:0] OP_READ  = 8'h01;
  localparam logic [7:0] OP_PROG  = 8'h02;
  localparam logic [7:0] OP_ERASE = 8'h03;

  localparam int SLOT_COUNT = 6;
  localparam int PHRASE_BITS = 64;

  // strobes from the sequencer to the array
  typedef struct packed {
    logic                   progEn;
    logic                   eraseEn;
    logic [15:0]            phraseIdx;
    logic [PHRASE_BITS-1:0] wdata;
  } arrStrobe_t;

endpackage

// File: rtl/fcc_array.sv
module fcc_array
  import flashctl_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int BLOCKS  = 2,
  parameter int PHRASES = 128,
  parameter int PPS     = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  arrStrobe_t             strb,
  input  logic [BLOCKS-1:0]      busyMask,
  output logic [PHRASE_BITS-1:0] cmdPhrase,
  input  logic                   rdReq,
  input  logic [ADDR_W-1:0]      rdAddr,
  input  logic                   rdWord,
  output logic                   rdValid,
  output logic [15:0]            rdData
);

  localparam int BLK_W = $clog2(BLOCKS);
  localparam int PH_W  = $clog2(PHRASES);

  logic [PHRASE_BITS-1:0] arr [PHRASES];
  logic [PH_W-1:0]        pIdx;
  logic [ADDR_W-1:0]      nxtAddr;
  logic                   misal, blocked, rdSecond;
  logic [7:0]             hiByte;

  assign pIdx      = strb.phraseIdx[PH_W-1:0];
  assign cmdPhrase = arr[pIdx];

  generate
    for (genvar p = 0; p < PHRASES; p++) begin : g_phrase
      always_ff @(posedge clk) begin
        if (!rstN) begin
          arr[p] <= '1;
        end else if (strb.eraseEn && ((int'(strb.phraseIdx) / PPS) == (p / PPS))) begin
          arr[p] <= '1;
        end else if (strb.progEn && (int'(strb.phraseIdx) == p)) begin
          arr[p] <= arr[p] & strb.wdata;
        end
      end
    end
  endgenerate

  function automatic logic [7:0] byteAt(input logic [ADDR_W-1:0] a);
    logic [PHRASE_BITS-1:0] ph;
    ph = arr[a[ADDR_W-1:3]];
    return ph[8*(7-int'(a[2:0])) +: 8];
  endfunction

  assign nxtAddr = rdAddr + ADDR_W'(1);
  assign misal   = rdWord && rdAddr[0];
  assign blocked = busyMask[rdAddr[ADDR_W-1 -: BLK_W]] ||
                   (rdWord && busyMask[nxtAddr[ADDR_W-1 -: BLK_W]]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid  <= 1'b0;
      rdSecond <= 1'b0;
      rdData   <= '0;
      hiByte   <= '0;
    end else begin
      rdValid <= 1'b0;
      if (rdSecond) begin
        rdData   <= {hiByte, byteAt(nxtAddr)};
        rdValid  <= 1'b1;
        rdSecond <= 1'b0;
      end else if (rdReq && !rdValid && !blocked) begin
        if (misal) begin
          hiByte   <= byteAt(rdAddr);
          rdSecond <= 1'b1;
        end else begin
          rdData  <= rdWord ? {byteAt(rdAddr), byteAt(nxtAddr)} : {8'h00, byteAt(rdAddr)};
          rdValid <= 1'b1;
        end
      end
    end
  end

  AST_READ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (!rdSecond && rdReq && blocked) |=> !rdValid); // R11
  AST_MISAL_TWO_CYCLES: assert property (@(posedge clk) disable iff (!rstN)
    (!rdSecond && rdReq && !rdValid && !blocked && misal) |=> !rdValid); // R10
  AST_PROG_CLEARS_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    strb.progEn |=> ((arr[$past(pIdx)] & ~$past(cmdPhrase)) == '0)); // R6
  AST_ERASE_FILLS: assert property (@(posedge clk) disable iff (!rstN)
    strb.eraseEn |=> (arr[$past(pIdx)] == '1)); // R7

endmodule

// File: rtl/fcc_ctrl.sv
module fcc_ctrl
  import flashctl_pkg::*;
#(
  parameter int ADDR_W       = 10,
  parameter int TOTAL_BYTES  = 1024,
  parameter int BLOCKS       = 2,
  parameter int PROG_CYCLES  = 40,
  parameter int ERASE_CYCLES = 200,
  parameter int READ_CYCLES  = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   regWe,
  input  logic [1:0]             regSel,
  input  logic [15:0]            regWdata,
  output logic [15:0]            regRdata,
  input  logic                   launch,
  input  logic [PHRASE_BITS-1:0] cmdPhrase,
  output arrStrobe_t             strb,
  output logic [BLOCKS-1:0]      busyMask,
  output logic                   cmdDone,
  output logic                   accErr,
  output logic                   progErr,
  output logic                   irq
);

  localparam int BLK_W   = $clog2(BLOCKS);
  localparam int MAX_A   = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
  localparam int MAX_CYC = (MAX_A > READ_CYCLES) ? MAX_A : READ_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic [15:0]      slot [SLOT_COUNT];
  logic [2:0]       idx;
  logic             busy, irqEn;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       curOp;
  logic [23:0]      fullAddr;
  logic [7:0]       code;
  logic             inRange, known, badAlign, finish, isErased;
  logic [BLK_W-1:0] blk;

  assign fullAddr = {slot[0][7:0], slot[1]};
  assign code     = slot[0][15:8];
  assign inRange  = fullAddr < 24'(TOTAL_BYTES);
  assign known    = (code == OP_READ) || (code == OP_PROG) || (code == OP_ERASE);
  assign badAlign = (code == OP_PROG) && (fullAddr[2:0] != 3'd0);
  assign isErased = &cmdPhrase;
  assign blk      = fullAddr[ADDR_W-1 -: BLK_W];
  assign finish   = busy && (cnt == '0);

  always_comb begin
    for (int b = 0; b < BLOCKS; b++) busyMask[b] = busy && (blk == BLK_W'(b));
  end

  assign strb.progEn    = finish && (curOp == OP_PROG);
  assign strb.eraseEn   = finish && (curOp == OP_ERASE);
  assign strb.phraseIdx = 16'(fullAddr >> 3);
  assign strb.wdata     = {slot[2], slot[3], slot[4], slot[5]};

  assign irq = cmdDone && irqEn;

  function automatic logic [CNT_W-1:0] opCycles(input logic [7:0] op);
    case (op)
      OP_PROG:  return CNT_W'(PROG_CYCLES - 1);
      OP_ERASE: return CNT_W'(ERASE_CYCLES - 1);
      default:  return CNT_W'(READ_CYCLES - 1);
    endcase
  endfunction

  always_comb begin
    case (regSel)
      2'd0:    regRdata = {13'd0, idx};
      2'd1:    regRdata = (idx < 3'(SLOT_COUNT)) ? slot[idx] : 16'd0;
      2'd2:    regRdata = {8'd0, cmdDone, 1'b0, accErr, progErr, 4'd0};
      default: regRdata = {15'd0, irqEn};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < SLOT_COUNT; i++) slot[i] <= '0;
      idx     <= '0;
      busy    <= 1'b0;
      cnt     <= '0;
      curOp   <= '0;
      irqEn   <= 1'b0;
      cmdDone <= 1'b1;
      accErr  <= 1'b0;
      progErr <= 1'b0;
    end else begin
      if (busy) begin
        if (cnt == '0) begin
          busy    <= 1'b0;
          cmdDone <= 1'b1;
          if (curOp == OP_READ) begin
            slot[2] <= cmdPhrase[63:48];
            slot[3] <= cmdPhrase[47:32];
            slot[4] <= cmdPhrase[31:16];
            slot[5] <= cmdPhrase[15:0];
          end
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
      if (regWe) begin
        case (regSel)
          2'd0: if (busy) accErr <= 1'b1; else idx <= regWdata[2:0];
          2'd1: if (busy) accErr <= 1'b1;
                else if (idx < 3'(SLOT_COUNT)) slot[idx] <= regWdata;
          2'd2: begin
            if (regWdata[5]) accErr  <= 1'b0;
            if (regWdata[4]) progErr <= 1'b0;
          end
          default: irqEn <= regWdata[0];
        endcase
      end
      if (launch) begin
        if (busy || !known || !inRange || badAlign) begin
          accErr <= 1'b1;
        end else if ((code == OP_PROG) && !isErased) begin
          progErr <= 1'b1;
        end else begin
          busy    <= 1'b1;
          cmdDone <= 1'b0;
          curOp   <= code;
          cnt     <= opCycles(code);
        end
      end
    end
  end

  AST_START_NEEDS_LAUNCH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cmdDone) |-> $past(launch)); // R3
  AST_LOCKED_SLOT_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (busy && regWe && (regSel == 2'd1)) |=> accErr); // R4
  AST_LOCKED_LAUNCH: assert property (@(posedge clk) disable iff (!rstN)
    (busy && launch) |=> (accErr && !$fell(cmdDone))); // R4
  AST_MISALIGNED_PROG: assert property (@(posedge clk) disable iff (!rstN)
    (launch && !busy && badAlign) |=> (accErr && cmdDone)); // R5
  AST_UNKNOWN_CMD: assert property (@(posedge clk) disable iff (!rstN)
    (launch && !busy && !known) |=> (accErr && cmdDone)); // R8

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flashctl_pkg::*;
#(
  parameter int BLOCKS            = 2,
  parameter int SECTORS_PER_BLOCK = 2,
  parameter int SECTOR_BYTES      = 256,
  parameter int PROG_CYCLES       = 40,
  parameter int ERASE_CYCLES      = 200,
  parameter int READ_CYCLES       = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic [1:0]  regSel,
  input  logic [15:0] regWdata,
  output logic [15:0] regRdata,
  input  logic        launch,
  input  logic        rdReq,
  input  logic [$clog2(BLOCKS*SECTORS_PER_BLOCK*SECTOR_BYTES)-1:0] rdAddr,
  input  logic        rdWord,
  output logic        rdValid,
  output logic [15:0] rdData,
  output logic        cmdDone,
  output logic        accErr,
  output logic        progErr,
  output logic        irq
);

  localparam int TOTAL_BYTES = BLOCKS * SECTORS_PER_BLOCK * SECTOR_BYTES;
  localparam int ADDR_W      = $clog2(TOTAL_BYTES);
  localparam int PHRASES     = TOTAL_BYTES / 8;
  localparam int PPS         = SECTOR_BYTES / 8;

  arrStrobe_t             strb;
  logic [BLOCKS-1:0]      busyMask;
  logic [PHRASE_BITS-1:0] cmdPhrase;

  fcc_ctrl #(
    .ADDR_W(ADDR_W), .TOTAL_BYTES(TOTAL_BYTES), .BLOCKS(BLOCKS),
    .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES), .READ_CYCLES(READ_CYCLES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel), .regWdata(regWdata),
    .regRdata(regRdata), .launch(launch), .cmdPhrase(cmdPhrase), .strb(strb),
    .busyMask(busyMask), .cmdDone(cmdDone), .accErr(accErr), .progErr(progErr), .irq(irq)
  );

  fcc_array #(
    .ADDR_W(ADDR_W), .BLOCKS(BLOCKS), .PHRASES(PHRASES), .PPS(PPS)
  ) u_array (
    .clk(clk), .rstN(rstN), .strb(strb), .busyMask(busyMask), .cmdPhrase(cmdPhrase),
    .rdReq(rdReq), .rdAddr(rdAddr), .rdWord(rdWord), .rdValid(rdValid), .rdData(rdData)
  );

endmodule

// File: tb/test_flash_cmd_ctrl.sv
module test_flash_cmd_ctrl;

  localparam int BLOCKS = 2, SPB = 2, SB = 256;
  localparam int PC = 6, EC = 12, RC = 2;
  localparam int TOTAL = BLOCKS * SPB * SB;
  localparam int AW = $clog2(TOTAL);

  logic clk = 1'b0, rstN = 1'b0;
  logic regWe = 1'b0, launch = 1'b0, rdReq = 1'b0, rdWord = 1'b0;
  logic [1:0] regSel = 2'd0;
  logic [15:0] regWdata = '0;
  logic [AW-1:0] rdAddr = '0;
  logic [15:0] regRdata, rdData;
  logic rdValid, cmdDone, accErr, progErr, irq;

  always #5 clk = ~clk;

  flash_cmd_ctrl #(.BLOCKS(BLOCKS), .SECTORS_PER_BLOCK(SPB), .SECTOR_BYTES(SB),
                   .PROG_CYCLES(PC), .ERASE_CYCLES(EC), .READ_CYCLES(RC)) i_flash_cmd_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel), .regWdata(regWdata),
    .regRdata(regRdata), .launch(launch), .rdReq(rdReq), .rdAddr(rdAddr), .rdWord(rdWord),
    .rdValid(rdValid), .rdData(rdData), .cmdDone(cmdDone), .accErr(accErr),
    .progErr(progErr), .irq(irq));

  int nChecks = 0, nFails = 0, cyc = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  bit mDone, mAcc, mProg, mIrqEn, mBusy, wasBusy;
  int mCnt, mOp, ma, mc, mBase;
  logic [2:0] mIdx;
  logic [15:0] mSlot [8];
  logic [7:0] mem [TOTAL];

  function automatic logic [7:0] slotByte(int k);
    return (k % 2 == 0) ? mSlot[2 + k / 2][15:8] : mSlot[2 + k / 2][7:0];
  endfunction

  function automatic logic [15:0] expRd(int a, bit word);
    return word ? {mem[a], mem[(a + 1) % TOTAL]} : {8'h00, mem[a]};
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mDone = 1; mAcc = 0; mProg = 0; mIrqEn = 0; mBusy = 0; mCnt = 0; mOp = 0; mIdx = 0;
      for (int i = 0; i < 8; i++) mSlot[i] = '0;
      for (int i = 0; i < TOTAL; i++) mem[i] = 8'hFF;
    end else begin
      wasBusy = mBusy;
      ma = {mSlot[0][7:0], mSlot[1]};
      if (mBusy) begin
        if (mCnt == 0) begin
          mBusy = 0; mDone = 1;
          if (mOp == 2) for (int k = 0; k < 8; k++) mem[ma + k] = mem[ma + k] & slotByte(k);
          else if (mOp == 3) begin
            mBase = (ma / SB) * SB;
            for (int k = 0; k < SB; k++) mem[mBase + k] = 8'hFF;
          end else begin
            mBase = (ma / 8) * 8;
            for (int j = 0; j < 4; j++) mSlot[2 + j] = {mem[mBase + 2*j], mem[mBase + 2*j + 1]};
          end
        end else mCnt--;
      end
      if (regWe) begin
        if (regSel == 0) begin if (wasBusy) mAcc = 1; else mIdx = regWdata[2:0]; end
        else if (regSel == 1) begin if (wasBusy) mAcc = 1; else if (mIdx < 6) mSlot[mIdx] = regWdata; end
        else if (regSel == 2) begin if (regWdata[5]) mAcc = 0; if (regWdata[4]) mProg = 0; end
        else mIrqEn = regWdata[0];
      end
      if (launch) begin
        ma = {mSlot[0][7:0], mSlot[1]};
        mc = mSlot[0][15:8];
        if (wasBusy || !(mc >= 1 && mc <= 3) || ma >= TOTAL || (mc == 2 && ma % 8 != 0)) mAcc = 1;
        else if (mc == 2 && {mem[ma], mem[ma+1], mem[ma+2], mem[ma+3],
                             mem[ma+4], mem[ma+5], mem[ma+6], mem[ma+7]} != 64'hFFFF_FFFF_FFFF_FFFF)
          mProg = 1;
        else begin
          mBusy = 1; mDone = 0; mOp = mc;
          mCnt = (mc == 2 ? PC : mc == 3 ? EC : RC) - 1;
        end
      end
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk(cmdDone == mDone, "R3 cmdDone vs model", 32'(cmdDone), 32'(mDone));
      chk(accErr == mAcc, "R4 accErr vs model", 32'(accErr), 32'(mAcc));
      chk(progErr == mProg, "R6 progErr vs model", 32'(progErr), 32'(mProg));
      chk(irq == (mDone && mIrqEn), "R13 irq vs model", 32'(irq), 32'(mDone && mIrqEn));
    end
  end

  task automatic summary();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000 && !finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog R3 actual=hung expected=completion");
      summary();
    end
  end

  task automatic wrReg(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk); regWe = 1; regSel = sel; regWdata = d;
    @(negedge clk); regWe = 0;
  endtask

  task automatic readReg(input logic [1:0] sel, output logic [15:0] v);
    @(negedge clk); regSel = sel; #1; v = regRdata;
  endtask

  task automatic setCmd(input logic [7:0] op, input logic [23:0] a, input logic [63:0] d);
    wrReg(0, 16'd0); wrReg(1, {op, a[23:16]});
    wrReg(0, 16'd1); wrReg(1, a[15:0]);
    for (int j = 0; j < 4; j++) begin
      wrReg(0, 16'(2 + j)); wrReg(1, d[63 - 16*j -: 16]);
    end
  endtask

  task automatic doLaunch();
    @(negedge clk); launch = 1;
    @(negedge clk); launch = 0;
  endtask

  task automatic runCmd(input int expLow, input string tag);
    int low = 0;
    doLaunch();
    while (!cmdDone && low < 1000) begin low++; @(negedge clk); end
    chk(low == expLow, tag, 32'(low), 32'(expLow));
  endtask

  task automatic waitDone();
    int n = 0;
    while (!cmdDone && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic readPort(input int a, input bit word, input int expLat, input string tag);
    int lat = 0;
    logic [15:0] e;
    e = expRd(a, word);
    @(negedge clk); rdReq = 1; rdAddr = AW'(a); rdWord = word;
    do begin @(negedge clk); lat++; end while (!rdValid && lat < 50);
    rdReq = 0;
    chk(lat == expLat, {tag, " latency"}, 32'(lat), 32'(expLat));
    chk(rdData == e, {tag, " data"}, 32'(rdData), 32'(e));
  endtask

  logic [15:0] v;
  int lat, doneSeen;

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk(cmdDone == 1, "R1 cmdDone after reset", 32'(cmdDone), 1);
    chk(accErr == 0 && progErr == 0, "R1 errors after reset", {accErr, progErr}, 0);
    readReg(2, v); chk(v == 16'h0080, "R1 status after reset", v, 16'h0080);
    readPort(0, 1, 1, "R1 erased word");
    readPort(TOTAL - 1, 0, 1, "R1 erased byte");

    // R2 slot readback and index register
    setCmd(8'h02, 24'h000008, 64'h1234_5678_9ABC_DEF0);
    wrReg(0, 16'd0); readReg(1, v); chk(v == 16'h0200, "R2 slot0", v, 16'h0200);
    wrReg(0, 16'd4); readReg(1, v); chk(v == 16'h9ABC, "R2 slot4", v, 16'h9ABC);
    readReg(0, v); chk(v == 16'd4, "R2 index readback", v, 4);
    wrReg(0, 16'd6); wrReg(1, 16'hAAAA); readReg(1, v); chk(v == 16'd0, "R2 slot6 discarded", v, 0);

    // R13 enable irq, R3/R5 program
    wrReg(3, 16'd1);
    chk(irq == 1, "R13 irq with enable and done", 32'(irq), 1);
    runCmd(PC, "R3 program busy window");
    readPort(8, 1, 1, "R5 R10 aligned word");
    chk(rdData == 16'h1234, "R5 programmed word", rdData, 16'h1234);
    readPort(9, 1, 2, "R10 misaligned word");
    readPort(15, 0, 1, "R10 byte read");

    // R6 second program without erase
    setCmd(8'h02, 24'h000008, 64'h0);
    doLaunch();
    chk(progErr == 1 && cmdDone == 1, "R6 reprogram rejected", {progErr, cmdDone}, 2'b11);
    readPort(8, 1, 1, "R6 contents unchanged");
    chk(rdData == 16'h1234, "R6 data kept", rdData, 16'h1234);
    // R9 W1C
    wrReg(2, 16'h0010);
    chk(progErr == 0, "R9 program error cleared", 32'(progErr), 0);

    // second program in sector 1 of block 0
    setCmd(8'h02, 24'h000108, 64'hA1A2_B3B4_C5C6_D7D8);
    runCmd(PC, "R3 program sector1 window");

    // R5 misaligned program
    setCmd(8'h02, 24'h000013, 64'h0);
    doLaunch();
    chk(accErr == 1 && cmdDone == 1, "R5 misaligned rejected", {accErr, cmdDone}, 2'b11);
    wrReg(2, 16'h0020);
    chk(accErr == 0, "R9 access error cleared", 32'(accErr), 0);
    // R8 unknown code and out of range
    setCmd(8'h7F, 24'h000000, 64'h0);
    doLaunch();
    chk(accErr == 1 && cmdDone == 1, "R8 unknown code", {accErr, cmdDone}, 2'b11);
    wrReg(2, 16'h0020);
    setCmd(8'h03, 24'(TOTAL), 64'h0);
    doLaunch();
    chk(accErr == 1 && cmdDone == 1, "R8 out of range", {accErr, cmdDone}, 2'b11);
    wrReg(2, 16'h0020);

    // R4 and R11 during an erase of block 0 sector 0
    setCmd(8'h03, 24'h000010, 64'h0);
    doLaunch();
    chk(irq == 0, "R13 irq low while busy", 32'(irq), 0);
    wrReg(1, 16'hBEEF);
    chk(accErr == 1, "R4 slot write while busy", 32'(accErr), 1);
    doLaunch();
    chk(cmdDone == 0, "R4 launch while busy keeps running", 32'(cmdDone), 0);
    readPort(16'h200, 1, 1, "R11 other block read");
    @(negedge clk); rdReq = 1; rdAddr = AW'(8); rdWord = 1;
    lat = 0; doneSeen = 0;
    do begin @(negedge clk); lat++; if (!rdValid && cmdDone) doneSeen++; end while (!rdValid && lat < 50);
    rdReq = 0;
    chk(doneSeen == 1, "R11 stalled read released after done", 32'(doneSeen), 1);
    chk(rdData == 16'hFFFF, "R7 R11 erased data", rdData, 16'hFFFF);
    wrReg(2, 16'h0020);
    wrReg(0, 16'd1); readReg(1, v);
    chk(v == 16'h0010, "R4 slot1 unchanged", v, 16'h0010);
    readPort(16'hFE, 1, 1, "R7 sector end erased");
    readPort(16'h108, 1, 1, "R7 other sector kept");
    chk(rdData == 16'hA1A2, "R7 other sector value", rdData, 16'hA1A2);

    // R12 read-phrase command (address low bits ignored)
    setCmd(8'h01, 24'h00010B, 64'h0);
    runCmd(RC, "R3 read command window");
    wrReg(0, 16'd2); readReg(1, v); chk(v == 16'hA1A2, "R12 slot2", v, 16'hA1A2);
    wrReg(0, 16'd5); readReg(1, v); chk(v == 16'hD7D8, "R12 slot5", v, 16'hD7D8);

    // R10 misaligned word across phrase boundary
    readPort(16'h10F, 1, 2, "R10 cross-phrase word");

    // R11 program block 1 while reading block 0
    setCmd(8'h02, 24'h000200, 64'h0102_0304_0506_0708);
    doLaunch();
    readPort(16'h10A, 1, 1, "R11 block0 read during block1 program");
    waitDone();
    readPort(16'h200, 1, 1, "R5 block1 program");
    chk(rdData == 16'h0102, "R5 block1 data", rdData, 16'h0102);

    // R13 disable interrupt
    wrReg(3, 16'd0);
    chk(irq == 0, "R13 irq off when disabled", 32'(irq), 0);

    repeat (3) @(negedge clk);
    summary();
  end

endmodule